// File: doc/BRIEF.md
# Module Power State Controller

This block sets the local reset and the clock enable of one peripheral module. Software writes a 3-bit requested state. After a short transition the block drives the module reset, the clock enable and a bus-ready line to match that state. Four of the six states are fixed combinations of reset and clock. The other two are automatic modes: the module idles with its clock stopped, and the block wakes it when a bus read/write request arrives.

In the automatic modes the requester is stalled, with ready low, for `WAKE_LAT` cycles while the clock enable is already high. After that the request is served. In the auto-sleep mode the clock stops again one cycle after the last handshake. In the auto-wake mode the block settles into the Enable state and stays there. The power-on state is chosen by the parameter `START_ENABLED`: 1 gives Enable, 0 gives reset-and-clock-off. A status port reports the current state code, together with a busy flag while a software write is still being applied.

Top module: `mod_power_ctl`

## Requirements
- R1: After reset with `START_ENABLED`=0, the status reads 3 with busy low, and reset, clock enable and ready are all low. With `START_ENABLED`=1, the status reads 0.
- R2: State codes and outputs (reset is active low, shown as rst_n/clk_en/ready):
  - 0 Enable drives 1/1/1.
  - 1 Disable drives 1/0/0.
  - 2 SyncReset drives 0/1/1.
  - 3 reset-and-clock-off drives 0/0/0.
  - A request in state 1 or 3 is never served.
- R3: A write with a valid code (0 to 5) while busy is low is accepted at that clock edge. Busy is high for the next cycle. The new status and outputs appear after the following edge, provided no wake is in progress.
- R4: A write while busy is high is ignored. A write with code 6 or 7 is ignored: busy stays low and the status is unchanged.
- R5: In auto-sleep (code 4) and auto-wake (code 5) while idle, rst_n is 1, clk_en is 0 and ready is 0, and the block holds this as long as no request arrives.
- R6: A request sampled at an edge while idle in code 4 or 5 raises clk_en after that edge. Ready stays low for exactly `WAKE_LAT` cycles and then goes high.
- R7: In code 4, after a handshake edge (request and ready both high), the clock stays on for one more cycle. It then turns off unless a request is high in that cycle, in which case the module stays awake.
- R8: In code 5, once the wake completes, the status becomes 0 (Enable) and clk_en and ready stay high after the request drops.
- R9: A write accepted during a wake sequence keeps busy high until the wake completes. It is applied one cycle after ready rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr | input | 1 | Software write strobe for a requested state |
| sw_code | input | 3 | Requested state code |
| bus_req | input | 1 | Bus read/write request to the module |
| mod_rst_n | output | 1 | Module reset, active low |
| mod_clk_en | output | 1 | Module clock enable |
| bus_ready | output | 1 | Request may complete; low stalls the requester |
| status_state | output | 3 | Current state code |
| status_busy | output | 1 | Software write accepted but not yet applied |

## Verification
A software write and a wake sequence can fall in the same cycles. The bench provokes this by writing a new code while the auto-sleep wake counter is running. It checks that busy stays high, that the status keeps code 4 until ready rises, and that the new state lands exactly one cycle later. A request arriving in the linger cycle after a handshake is also driven on purpose, to check that the clock stays on. A long random run of writes, including invalid codes and writes while busy, mixed with request patterns, is then compared every cycle against a cycle model in the bench.

// File: rtl/mpc_pkg.sv
// Package: state and phase encodings shared by the power state controller.
// Assumes codes 6 and 7 are never valid requested states.
package mpc_pkg;
    typedef enum logic [2:0] {
        ST_ENABLE    = 3'd0,
        ST_DISABLE   = 3'd1,
        ST_SYNCRST   = 3'd2,
        ST_RSTOFF    = 3'd3,
        ST_AUTOSLEEP = 3'd4,
        ST_AUTOWAKE  = 3'd5
    } pstate_e;

    typedef enum logic [1:0] {
        PH_SLEEP  = 2'd0,
        PH_WAKE   = 2'd1,
        PH_AWAKE  = 2'd2,
        PH_LINGER = 2'd3
    } phase_e;

    function automatic logic is_auto(pstate_e s);
        return (s == ST_AUTOSLEEP) || (s == ST_AUTOWAKE);
    endfunction

    function automatic logic code_ok(logic [2:0] c);
        return c <= 3'd5;
    endfunction
endpackage

// File: rtl/mpc_sw_ctl.sv
// Software request latch and current-state register.
// Holds one accepted write until no wake is in progress, then applies it.
// Assumes wake_finish only pulses while wake_active is high.
module mpc_sw_ctl
    import mpc_pkg::*;
#(
    parameter bit START_ENABLED = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_wr,
    input  logic [2:0] sw_code,
    input  logic       wake_active,
    input  logic       wake_finish,
    output pstate_e    cur_state,
    output logic       busy,
    output logic       apply
);
    localparam pstate_e RESET_STATE = START_ENABLED ? ST_ENABLE : ST_RSTOFF;

    logic    pend_valid;
    pstate_e pend_state;

    assign busy  = pend_valid;
    assign apply = pend_valid && !wake_active;

    // Accept a valid write when idle; clear it once applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_state <= RESET_STATE;
        end else if (apply) begin
            pend_valid <= 1'b0;
        end else if (!pend_valid && sw_wr && code_ok(sw_code)) begin
            pend_valid <= 1'b1;
            pend_state <= pstate_e'(sw_code);
        end
    end

    // Current state: software apply, or auto-wake settling into Enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_state <= RESET_STATE;
        end else if (apply) begin
            cur_state <= pend_state;
        end else if (wake_finish && cur_state == ST_AUTOWAKE) begin
            cur_state <= ST_ENABLE;
        end
    end

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wake_active) |=> busy);

    // R4
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sw_wr && !apply) |=> $stable(pend_state));

    // R3
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sw_wr && code_ok(sw_code)) |=> (busy && pend_state == pstate_e'($past(sw_code))));
endmodule

// File: rtl/mpc_wake_seq.sv
// Wake sequencer for the automatic modes: idle, wake countdown, serve, linger.
// Assumes a pending software apply takes priority and returns it to idle.
module mpc_wake_seq
    import mpc_pkg::*;
#(
    parameter int WAKE_LAT = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  pstate_e cur_state,
    input  logic    apply,
    input  logic    bus_req,
    output phase_e  phase,
    output logic    wake_finish
);
    localparam int CW = $clog2(WAKE_LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_LAT - 1);

    logic [CW-1:0] cnt;

    assign wake_finish = (phase == PH_WAKE) && (cnt == LAST);

    // Phase and latency counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_SLEEP;
            cnt   <= '0;
        end else if (apply) begin
            phase <= PH_SLEEP;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_SLEEP: begin
                    if (is_auto(cur_state) && bus_req) begin
                        phase <= PH_WAKE;
                        cnt   <= '0;
                    end
                end
                PH_WAKE: begin
                    if (cnt == LAST) phase <= PH_AWAKE;
                    else             cnt   <= cnt + 1'b1;
                end
                PH_AWAKE: begin
                    if (bus_req) phase <= PH_LINGER;
                end
                default: begin
                    if (!bus_req) phase <= PH_SLEEP;
                end
            endcase
        end
    end

    // R5
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SLEEP && !bus_req && !apply) |=> phase == PH_SLEEP);

    // R6
    wake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SLEEP && is_auto(cur_state) && bus_req && !apply) |=> (phase == PH_WAKE && cnt == '0));

    // R7
    linger_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LINGER && cur_state == ST_AUTOSLEEP && !bus_req && !apply) |=> phase == PH_SLEEP);
endmodule

// File: rtl/mpc_out_dec.sv
// Output decoder: maps current state and wake phase to reset, clock enable, ready.
// Purely combinational; assumes phase is idle outside the automatic modes.
module mpc_out_dec
    import mpc_pkg::*;
(
    input  pstate_e cur_state,
    input  phase_e  phase,
    output logic    mod_rst_n,
    output logic    mod_clk_en,
    output logic    bus_ready
);
    // Per-state output combination.
    always_comb begin
        mod_rst_n  = 1'b1;
        mod_clk_en = 1'b0;
        bus_ready  = 1'b0;
        case (cur_state)
            ST_ENABLE: begin
                mod_clk_en = 1'b1;
                bus_ready  = 1'b1;
            end
            ST_DISABLE: begin
            end
            ST_SYNCRST: begin
                mod_rst_n  = 1'b0;
                mod_clk_en = 1'b1;
                bus_ready  = 1'b1;
            end
            ST_RSTOFF: begin
                mod_rst_n  = 1'b0;
            end
            default: begin
                mod_clk_en = (phase != PH_SLEEP);
                bus_ready  = (phase == PH_AWAKE) || (phase == PH_LINGER);
            end
        endcase
    end
endmodule

// File: rtl/mod_power_ctl.sv
// Top: power state controller for one peripheral module.
// Ties the software latch, wake sequencer and output decoder together.
// Assumes WAKE_LAT >= 1; the clock gate itself sits outside this block.
module mod_power_ctl
    import mpc_pkg::*;
#(
    parameter int WAKE_LAT      = 4,
    parameter bit START_ENABLED = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_wr,
    input  logic [2:0] sw_code,
    input  logic       bus_req,
    output logic       mod_rst_n,
    output logic       mod_clk_en,
    output logic       bus_ready,
    output logic [2:0] status_state,
    output logic       status_busy
);
    pstate_e cur_state;
    phase_e  phase;
    logic    busy;
    logic    apply;
    logic    wake_finish;
    logic    wake_active;

    assign wake_active  = (phase == PH_WAKE);
    assign status_state = cur_state;
    assign status_busy  = busy;

    mpc_sw_ctl #(.START_ENABLED(START_ENABLED)) u_sw (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_code(sw_code),
        .wake_active(wake_active), .wake_finish(wake_finish),
        .cur_state(cur_state), .busy(busy), .apply(apply)
    );

    mpc_wake_seq #(.WAKE_LAT(WAKE_LAT)) u_seq (
        .clk(clk), .rst_n(rst_n), .cur_state(cur_state), .apply(apply),
        .bus_req(bus_req), .phase(phase), .wake_finish(wake_finish)
    );

    mpc_out_dec u_dec (
        .cur_state(cur_state), .phase(phase),
        .mod_rst_n(mod_rst_n), .mod_clk_en(mod_clk_en), .bus_ready(bus_ready)
    );

    // R6
    wake_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_auto(cur_state) && mod_clk_en && !bus_ready) |=> mod_clk_en);

    // R3
    rst_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_rst_n) |-> $past(busy));

    // R8
    autowake_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_ENABLE && !busy) |=> (mod_clk_en && bus_ready));
endmodule

// File: tb/mod_power_ctl_bench.sv
module mod_power_ctl_bench;
    localparam int N = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_wr = 1'b0;
    logic [2:0] sw_code = 3'd0;
    logic bus_req = 1'b0;
    logic mod_rst_n, mod_clk_en, bus_ready, status_busy;
    logic [2:0] status_state;

    int tests = 0;
    int fails = 0;

    // bench cycle model
    int m_cur, m_ph, m_cnt, m_ps;
    bit m_pv;

    always #5 clk = ~clk;

    mod_power_ctl #(.WAKE_LAT(N), .START_ENABLED(1'b0)) u_mod_power_ctl (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_code(sw_code),
        .bus_req(bus_req), .mod_rst_n(mod_rst_n), .mod_clk_en(mod_clk_en),
        .bus_ready(bus_ready), .status_state(status_state), .status_busy(status_busy)
    );

    function automatic bit f_auto(int s);
        return (s == 4) || (s == 5);
    endfunction
    function automatic bit f_rst_n(int s);
        return !((s == 2) || (s == 3));
    endfunction
    function automatic bit f_clk(int s, int ph);
        return (s == 0) || (s == 2) || (f_auto(s) && ph != 0);
    endfunction
    function automatic bit f_ready(int s, int ph);
        return (s == 0) || (s == 2) || (f_auto(s) && ph >= 2);
    endfunction

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step_model(bit wr, int code, bit req);
        bit ap, fin;
        ap  = m_pv && (m_ph != 1);
        fin = (m_ph == 1) && (m_cnt == N - 1);
        if (ap) m_pv = 0;
        else if (!m_pv && wr && code <= 5) begin m_pv = 1; m_ps = code; end
        if (ap) begin m_ph = 0; m_cnt = 0; end
        else case (m_ph)
            0: if (f_auto(m_cur) && req) begin m_ph = 1; m_cnt = 0; end
            1: if (fin) m_ph = 2; else m_cnt++;
            2: if (req) m_ph = 3;
            default: if (!req) m_ph = 0;
        endcase
        if (ap) m_cur = m_ps;
        else if (fin && m_cur == 5) m_cur = 0;
    endtask

    task automatic cmp_model();
        chk("R3 state", status_state, m_cur);
        chk("R4 busy", status_busy, m_pv);
        chk("R2 rst_n", mod_rst_n, f_rst_n(m_cur));
        chk("R6 clk_en", mod_clk_en, f_clk(m_cur, m_ph));
        chk("R7 ready", bus_ready, f_ready(m_cur, m_ph));
    endtask

    task automatic cyc(bit wr, int code, bit req);
        @(negedge clk);
        sw_wr = wr; sw_code = code[2:0]; bus_req = req;
        step_model(wr, code, req);
        @(posedge clk);
        #2;
        cmp_model();
    endtask

    task automatic wr_state(int code);
        cyc(1, code, 0);
        cyc(0, 0, 0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cur = 3; m_ph = 0; m_cnt = 0; m_pv = 0; m_ps = 3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 state", status_state, 3);
        chk("R1 busy", status_busy, 0);
        chk("R1 rst_n", mod_rst_n, 0);
        chk("R1 clk_en", mod_clk_en, 0);
        chk("R1 ready", bus_ready, 0);

        // R3 accept then apply
        cyc(1, 0, 0);
        chk("R3 busy after write", status_busy, 1);
        chk("R3 state held", status_state, 3);
        cyc(0, 0, 0);
        chk("R3 applied", status_state, 0);
        chk("R2 enable clk", mod_clk_en, 1);
        chk("R2 enable ready", bus_ready, 1);

        // R4 write while busy ignored
        cyc(1, 1, 0);
        cyc(1, 2, 0);
        chk("R4 busy write ignored", status_state, 1);
        cyc(0, 0, 1);
        chk("R4 state kept", status_state, 1);
        chk("R2 disable ready", bus_ready, 0);
        chk("R2 disable clk", mod_clk_en, 0);
        // R4 invalid code
        cyc(1, 7, 0);
        chk("R4 invalid busy", status_busy, 0);
        cyc(0, 0, 0);
        chk("R4 invalid state", status_state, 1);

        // R2 SyncReset and reset-off
        wr_state(2);
        chk("R2 syncrst rst_n", mod_rst_n, 0);
        chk("R2 syncrst clk", mod_clk_en, 1);
        wr_state(3);
        cyc(0, 0, 1);
        chk("R2 rstoff ready", bus_ready, 0);
        chk("R2 rstoff clk", mod_clk_en, 0);

        // R5 auto-sleep idle
        wr_state(4);
        cyc(0, 0, 0);
        chk("R5 idle rst_n", mod_rst_n, 1);
        chk("R5 idle clk", mod_clk_en, 0);
        chk("R5 idle ready", bus_ready, 0);

        // R6 wake latency N
        for (int k = 0; k < N; k++) begin
            cyc(0, 0, 1);
            chk("R6 stall clk", mod_clk_en, 1);
            chk("R6 stall ready", bus_ready, 0);
        end
        cyc(0, 0, 1);
        chk("R6 ready after N", bus_ready, 1);
        // R7 handshake then linger then sleep
        cyc(0, 0, 1);
        chk("R7 linger clk", mod_clk_en, 1);
        cyc(0, 0, 0);
        chk("R7 back to sleep", mod_clk_en, 0);
        // R7 request in linger cycle keeps awake
        repeat (N + 2) cyc(0, 0, 1);
        chk("R7 linger req clk", mod_clk_en, 1);
        cyc(0, 0, 1);
        chk("R7 still awake", mod_clk_en, 1);
        cyc(0, 0, 0);
        chk("R7 sleep after", mod_clk_en, 0);

        // R8 auto-wake stays enabled
        wr_state(5);
        repeat (N + 1) cyc(0, 0, 1);
        chk("R8 state enable", status_state, 0);
        cyc(0, 0, 0);
        cyc(0, 0, 0);
        chk("R8 clk stays", mod_clk_en, 1);
        chk("R8 ready stays", bus_ready, 1);

        // R9 write during wake is deferred
        wr_state(4);
        cyc(0, 0, 1);
        cyc(1, 1, 1);
        chk("R9 busy in wake", status_busy, 1);
        cyc(0, 0, 1);
        chk("R9 state held", status_state, 4);
        cyc(0, 0, 1);
        chk("R9 ready rose", bus_ready, 1);
        chk("R9 still busy", status_busy, 1);
        cyc(0, 0, 0);
        chk("R9 applied", status_state, 1);
        chk("R9 busy clear", status_busy, 0);

        // random run against the model
        for (int i = 0; i < 4000; i++) begin
            bit w;
            w = ($urandom % 6) == 0;
            cyc(w, (($urandom % 3) == 0) ? 4 + ($urandom % 2) : ($urandom % 8), ($urandom % 3) != 0);
        end
        summary();
    end
endmodule